// File: doc/BRIEF.md
# Outbound Address Translation Table

This block sits between a CPU-side bus master and a PCIe transmit path. It maps CPU addresses onto PCIe addresses. A table of eight programmable windows describes the mapping. Each window holds a 64-bit source base, a power-of-two size, an enable, a 64-bit translated base and a parameter word. The parameter word carries a small type ID and a wider parameter field. Both are returned with the translated address. Memory and I/O ranges use the same table, and no separate path exists for I/O.

Software programs the windows through a simple 32-bit register port. Each window takes five words in a fixed stride. The size of a window is encoded in the low bits of its source-low word as log2(size) − 1, next to the enable bit. A request presents a 64-bit address. The match against all windows is combinational, and one clock later the block returns a registered result: a hit flag, the translated address, the type ID and the parameter field. When several windows match, the lowest-numbered window wins. When none matches, the address passes through unchanged.

Top module: `ob_xlate_top`

## Requirements
- R1: After synchronous reset, rsp_valid and rsp_hit are 0 and every table word reads back as 0, so every window is disabled.
- R2: Window n (0..7) occupies cfg addresses 0x800 + 32·n. The word offsets are +0x0 source low, +0x4 source high, +0x8 translated low, +0xC translated high and +0x10 parameter. In the source-low word, bit 0 is the enable and bits 6:1 are the size code. A write stores all 32 bits. A read asserted in one cycle returns the stored word on cfg_rdata after the next clock edge.
- R3: A write to any other cfg address changes no window. This covers addresses outside 0x800..0x8FF and offsets 0x14..0x1C inside an entry. A read of such an address returns 0. Address bits 1:0 are ignored.
- R4: Let K = size code + 1. The comparison base is the 64-bit source word with bits 6:0 taken as 0. A request hits an enabled window when it equals this base in every bit at position K and above.
- R5: On a hit, rsp_addr is the translated base with its low K bits replaced by the request's low K bits. With a size code of 63, the whole request address is returned.
- R6: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R7: When more than one window hits, the window with the lowest index provides rsp_addr, rsp_id and rsp_param.
- R8: On a miss, rsp_hit is 0, rsp_addr equals the request address, and rsp_id and rsp_param are 0.
- R9: On a hit, rsp_id is bits 3:0 of the winning parameter word and rsp_param is bits 27:16 of it.
- R10: A request with req_valid high at a clock edge produces its result on the rsp_* outputs right after that edge. rsp_valid is high for exactly those cycles. The rsp_* data outputs hold their values while req_valid is low.
- R11: A table write takes effect for requests sampled at the following clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | CPU-side address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_id | output | 4 | Type ID of the winning window |
| rsp_param | output | 12 | Parameter field of the winning window |

## Verification
The bench targets windows that overlap. A design with a reversed priority order would return the higher window's translated base and ID. It covers the extreme size codes. A size code of 63 must pass the whole request address through, and a design that shifts a 64-bit one would wrap the mask and miss. A size code of 0 must treat the enable and size bits as zero base bits. Disabled windows and miss cases must return the raw address with zero ID and parameter, and leaking the last winner's fields fails these checks. Writes to reserved offsets and unmapped addresses are read back. A loose decoder would alias them onto a real entry and corrupt a window.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 2 * WORD_W;
  localparam int ID_W     = 4;
  localparam int PRM_W    = 12;
  localparam int PRM_LSB  = 16;
  localparam int SC_LSB   = 1;
  localparam int SC_W     = 6;
  localparam int BASE_LSB = SC_LSB + SC_W;
  localparam int WORDS_PER_WIN = 5;

  typedef struct packed {
    logic [WORD_W-1:0] src_lo;
    logic [WORD_W-1:0] src_hi;
    logic [WORD_W-1:0] dst_lo;
    logic [WORD_W-1:0] dst_hi;
    logic [WORD_W-1:0] prm;
  } win_t;

  // mask of the low (code+1) bits; code 63 selects all 64 bits
  function automatic logic [ADDR_W-1:0] span_mask(input logic [SC_W-1:0] code);
    logic [SC_W:0] k;
    k = {1'b0, code} + 1'b1;
    if (k[SC_W]) return '1;
    return (ADDR_W'(1) << k[SC_W-1:0]) - ADDR_W'(1);
  endfunction
endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int CFG_AW   = 12,
  parameter int TBL_BASE = 'h800,
  parameter int STRIDE_SH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output win_t              win_o [NUM_WIN]
);
  localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int REGION_SH = STRIDE_SH + IDX_W;
  localparam int WSEL_W    = STRIDE_SH - 2;

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic              in_region;
  logic              addr_ok;

  assign idx       = cfg_addr[REGION_SH-1:STRIDE_SH];
  assign wsel      = cfg_addr[STRIDE_SH-1:2];
  assign in_region = (cfg_addr >> REGION_SH) == CFG_AW'(TBL_BASE >> REGION_SH);
  assign addr_ok   = in_region && (int'(idx) < NUM_WIN) && (int'(wsel) < WORDS_PER_WIN);

  win_t tbl [NUM_WIN];

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[n] <= '0;
      end else if (cfg_we && addr_ok && (int'(idx) == n)) begin
        case (wsel)
          WSEL_W'(0): tbl[n].src_lo <= cfg_wdata;
          WSEL_W'(1): tbl[n].src_hi <= cfg_wdata;
          WSEL_W'(2): tbl[n].dst_lo <= cfg_wdata;
          WSEL_W'(3): tbl[n].dst_hi <= cfg_wdata;
          default:    tbl[n].prm    <= cfg_wdata;
        endcase
      end
    end
    assign win_o[n] = tbl[n];
  end

  win_t rd_win;
  always_comb begin
    rd_win = '0;
    for (int n = 0; n < NUM_WIN; n++)
      if (int'(idx) == n) rd_win = tbl[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_re) begin
      if (!addr_ok) cfg_rdata <= '0;
      else begin
        case (wsel)
          WSEL_W'(0): cfg_rdata <= rd_win.src_lo;
          WSEL_W'(1): cfg_rdata <= rd_win.src_hi;
          WSEL_W'(2): cfg_rdata <= rd_win.dst_lo;
          WSEL_W'(3): cfg_rdata <= rd_win.dst_hi;
          default:    cfg_rdata <= rd_win.prm;
        endcase
      end
    end
  end

  // R3: reads of unmapped offsets return zero
  p_unmapped_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && !addr_ok) |=> (cfg_rdata == '0));
endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
  import ob_xlate_pkg::*;
(
  input  win_t              win,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr,
  output logic [ID_W-1:0]   tid,
  output logic [PRM_W-1:0]  prm
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] dst;
  logic [ADDR_W-1:0] mask;
  logic              en;

  assign en   = win.src_lo[0];
  assign base = {win.src_hi, win.src_lo[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign dst  = {win.dst_hi, win.dst_lo};
  assign mask = span_mask(win.src_lo[SC_LSB +: SC_W]);

  assign hit   = en && (((req_addr ^ base) & ~mask) == '0);
  assign xaddr = (dst & ~mask) | (req_addr & mask);
  assign tid   = win.prm[ID_W-1:0];
  assign prm   = win.prm[PRM_LSB +: PRM_W];

  // R6: a disabled window never reports a hit
  always_comb begin
    if (win.src_lo[0] == 1'b0)
      p_disabled_no_hit_r6: assert (hit == 1'b0);
  end
endmodule

// File: rtl/ob_xlate_pick.sv
module ob_xlate_pick
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [ADDR_W-1:0] xaddr [NUM_WIN],
  input  logic [ID_W-1:0]   tid   [NUM_WIN],
  input  logic [PRM_W-1:0]  prm   [NUM_WIN],
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ID_W-1:0]   rsp_id,
  output logic [PRM_W-1:0]  rsp_param
);
  logic              nx_hit;
  logic [ADDR_W-1:0] nx_addr;
  logic [ID_W-1:0]   nx_id;
  logic [PRM_W-1:0]  nx_prm;

  // walk from the top so the lowest index is written last and wins
  always_comb begin
    nx_hit  = 1'b0;
    nx_addr = req_addr;
    nx_id   = '0;
    nx_prm  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        nx_hit  = 1'b1;
        nx_addr = xaddr[i];
        nx_id   = tid[i];
        nx_prm  = prm[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_id    <= '0;
      rsp_param <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= nx_hit;
        rsp_addr  <= nx_addr;
        rsp_id    <= nx_id;
        rsp_param <= nx_prm;
      end
    end
  end

  // R8: a miss passes the request address through
  p_miss_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr)));
  // R8: a miss carries no ID or parameter
  p_miss_zero_fields_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_id == '0 && rsp_param == '0));
  // R10: valid follows the request by one edge
  p_valid_latency_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10: data outputs hold while idle
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !$past(rst)) |=> ($stable(rsp_addr) && $stable(rsp_hit)));
endmodule

// File: rtl/ob_xlate_top.sv
module ob_xlate_top
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int CFG_AW   = 12,
  parameter int TBL_BASE = 'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [63:0]       rsp_addr,
  output logic [3:0]        rsp_id,
  output logic [11:0]       rsp_param
);
  win_t              win   [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [ADDR_W-1:0] xaddr [NUM_WIN];
  logic [ID_W-1:0]   tid   [NUM_WIN];
  logic [PRM_W-1:0]  prm   [NUM_WIN];

  ob_xlate_regs #(
    .NUM_WIN (NUM_WIN),
    .CFG_AW  (CFG_AW),
    .TBL_BASE(TBL_BASE),
    .STRIDE_SH(5)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_re   (cfg_re),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .win_o    (win)
  );

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_match
    ob_xlate_match u_match (
      .win     (win[n]),
      .req_addr(req_addr),
      .hit     (hit_vec[n]),
      .xaddr   (xaddr[n]),
      .tid     (tid[n]),
      .prm     (prm[n])
    );
  end

  ob_xlate_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .hit_vec  (hit_vec),
    .xaddr    (xaddr),
    .tid      (tid),
    .prm      (prm),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_addr (rsp_addr),
    .rsp_id   (rsp_id),
    .rsp_param(rsp_param)
  );
endmodule

// File: tb/ob_xlate_top_tb.sv
module ob_xlate_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_id;
  logic [11:0] rsp_param;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_tbl [NW][5];

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_xlate_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_addr(rsp_addr), .rsp_id(rsp_id), .rsp_param(rsp_param)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] waddr(input int n, input int off);
    return 12'(32'h800 + n * 32 + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[11:8] == 4'h8 && a[4:2] < 3'd5) m_tbl[a[7:5]][a[4:2]] = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic set_win(input int n, input logic [63:0] src, input int sc, input bit en,
                         input logic [63:0] dst, input logic [31:0] pw);
    wr(waddr(n, 4), src[63:32]);
    wr(waddr(n, 8), dst[31:0]);
    wr(waddr(n, 12), dst[63:32]);
    wr(waddr(n, 16), pw);
    wr(waddr(n, 0), {src[31:7], 6'(sc), en});
  endtask

  task automatic clear_all();
    for (int n = 0; n < NW; n++) wr(waddr(n, 0), 32'h0);
  endtask

  function automatic void model(input logic [63:0] a, output bit h, output logic [63:0] x,
                                output logic [3:0] id, output logic [11:0] pm);
    h = 0; x = a; id = '0; pm = '0;
    for (int n = NW - 1; n >= 0; n--) begin
      logic [63:0] base, dst, mask;
      int k;
      k = int'(m_tbl[n][0][6:1]) + 1;
      mask = (k >= 64) ? '1 : ((64'd1 << k) - 64'd1);
      base = {m_tbl[n][1], m_tbl[n][0][31:7], 7'b0};
      dst  = {m_tbl[n][3], m_tbl[n][2]};
      if (m_tbl[n][0][0] && (((a ^ base) & ~mask) == 64'd0)) begin
        h = 1; x = (dst & ~mask) | (a & mask);
        id = m_tbl[n][4][3:0]; pm = m_tbl[n][4][27:16];
      end
    end
  endfunction

  task automatic lookup(input logic [63:0] a, input string tag);
    bit h; logic [63:0] x; logic [3:0] id; logic [11:0] pm;
    model(a, h, x, id, pm);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid R10"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit R4"}, 64'(rsp_hit), 64'(h));
    chk({tag, " addr R5/R8"}, rsp_addr, x);
    chk({tag, " id R9"}, 64'(rsp_id), 64'(id));
    chk({tag, " param R9"}, 64'(rsp_param), 64'(pm));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] held;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int n = 0; n < NW; n++) for (int w = 0; w < 5; w++) m_tbl[n][w] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_hit", 64'(rsp_hit), 64'd0);
    rd(waddr(3, 8), d); chk("R1 readback zero", 64'(d), 64'd0);
    lookup(64'hDEAD_BEEF_0000_1234, "R1 empty table R8");

    // R2 readback of all words
    set_win(5, 64'h1234_5678_9ABC_DE80, 20, 1, 64'hCAFE_0000_F00D_0000, 32'h0ABC_0007);
    rd(waddr(5, 0), d);  chk("R2 src_lo", 64'(d), 64'(m_tbl[5][0]));
    rd(waddr(5, 4), d);  chk("R2 src_hi", 64'(d), 64'h1234_5678);
    rd(waddr(5, 8), d);  chk("R2 dst_lo", 64'(d), 64'hF00D_0000);
    rd(waddr(5, 12), d); chk("R2 dst_hi", 64'(d), 64'hCAFE_0000);
    rd(waddr(5, 19), d); chk("R2 prm low bits ignored", 64'(d), 64'h0ABC_0007);

    // R3 unmapped writes and reads
    wr(waddr(5, 20), 32'hFFFF_FFFF);
    wr(12'h700, 32'hFFFF_FFFF);
    wr(12'h9A0, 32'hFFFF_FFFF);
    rd(waddr(5, 20), d); chk("R3 reserved read", 64'(d), 64'd0);
    rd(12'h9A0, d);      chk("R3 outside read", 64'(d), 64'd0);
    rd(waddr(5, 0), d);  chk("R3 entry intact", 64'(d), 64'(m_tbl[5][0]));
    rd(waddr(0, 0), d);  chk("R3 entry0 intact", 64'(d), 64'd0);
    lookup(64'h1234_5678_9ABC_DE80 + 64'h123, "R3 window unchanged");

    // R7 priority on overlap
    clear_all();
    set_win(5, 64'h0000_0001_0001_0000, 11, 1, 64'h5555_0000_0000_0000, 32'h0055_0005);
    set_win(2, 64'h0000_0001_0001_0000, 15, 1, 64'h2222_0000_0000_0000, 32'h0022_0002);
    lookup(64'h0000_0001_0001_0123, "R7 overlap low index");
    lookup(64'h0000_0001_0001_8123, "R7 only wide window");
    // R6 disable
    wr(waddr(2, 0), m_tbl[2][0] & 32'hFFFF_FFFE);
    lookup(64'h0000_0001_0001_0123, "R6 disabled falls to next");
    wr(waddr(5, 0), m_tbl[5][0] & 32'hFFFF_FFFE);
    lookup(64'h0000_0001_0001_0123, "R6 all disabled R8");

    // R5 extreme size codes
    clear_all();
    set_win(0, 64'h0, 63, 1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h000F_0009);
    lookup(64'h8765_4321_0FED_CBA9, "R5 full span");
    clear_all();
    set_win(0, 64'h0000_0000_0000_1000, 0, 1, 64'hAAAA_AAAA_AAAA_AAA0, 32'h0FFF_000F);
    lookup(64'h0000_0000_0000_1001, "R5 code0 hit");
    lookup(64'h0000_0000_0000_1002, "R5 code0 miss");

    // R10 hold while idle
    held = rsp_addr;
    repeat (3) @(negedge clk);
    chk("R10 valid low idle", 64'(rsp_valid), 64'd0);
    chk("R10 addr held", rsp_addr, held);

    // random mix, R4 R5 R7 R9 R11
    for (int r = 0; r < 5; r++) begin
      for (int n = 0; n < NW; n++)
        set_win(n, {$urandom, $urandom}, 7 + ($urandom % 40), ($urandom % 4) != 0,
                {$urandom, $urandom}, $urandom);
      for (int q = 0; q < 40; q++) begin
        logic [63:0] a;
        int w;
        w = $urandom % NW;
        a = {$urandom, $urandom};
        if (q % 2 == 0) begin
          logic [63:0] mask; int k;
          k = int'(m_tbl[w][0][6:1]) + 1;
          mask = (k >= 64) ? '1 : ((64'd1 << k) - 64'd1);
          a = ({m_tbl[w][1], m_tbl[w][0][31:7], 7'b0} & ~mask) | (a & mask);
        end
        lookup(a, "R11 random");
      end
      rd(waddr(r, 16), d); chk("R2 random readback", 64'(d), 64'(m_tbl[r][4]));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule